// File: doc/BRIEF.md
# Multi-Mode Interleaved Pixel Serializer

The block turns bytes of video memory into a stream of 4-bit colour indices, one index per dot-clock enable. Three display modes trade horizontal resolution for colour depth: 2 colours with eight 1-dot pixels per byte, 4 colours with four 2-dot pixels, and 16 colours with two 4-dot pixels. In every mode each byte fills 8 dot clocks. A palette stage downstream turns the index into a colour.

Every colour bit comes from one 8-bit shift register. The register moves one bit position toward the MSB on each shift event, and the index is read from four fixed taps. In the lower-depth modes the unused index bits are forced to zero. Because the taps are fixed, the 16-colour mode stores its bits in a non-ascending order. The colour-bit-1 tap sits at the same register position in the 4-colour and 16-colour modes.

A controller pulses `load_en` with a new byte every 8 dot clocks. The mode is sampled only at a load. `blank_n` gates the output without disturbing the shift register or the divider phase.

Top module: `pixel_serializer`

## Requirements
- R1: While `rst` is high at a clock edge, `color_idx` becomes 0 at that edge. The shift register and the rate divider clear, and the latched mode becomes 2-colour.
- R2: In 2-colour mode, pixel p (p = 0..7) of a byte b has index {3'b000, b[7-p]}. Each pixel lasts one dot-enable.
- R3: In 4-colour mode, pixel p (p = 0..3) has index {2'b00, b[3-p], b[7-p]}. Each pixel lasts two dot-enables.
- R4: In 16-colour mode, pixel p (p = 0..1) has index {b[1-p], b[5-p], b[3-p], b[7-p]}, written as index bits 3,2,1,0. Each pixel lasts four dot-enables.
- R5: The mode select is encoded as 2'b00 for 16 colours, 2'b01 for 4 colours and 2'b10 for 2 colours. The value 2'b11 behaves as 2 colours.
- R6: A load takes effect whether or not `dot_en` is high, and it wins over a shift in the same cycle. Pixel 0 of the new byte appears at the same edge, and the divider phase restarts.
- R7: Changing `mode_sel` between loads has no effect until the next load.
- R8: `blank_n` low at an edge makes `color_idx` 0 at that edge. Shifting and the divider phase continue unchanged, so once `blank_n` returns high the correct pixel for the elapsed dots is shown.
- R9: With `load_en` and `dot_en` both low and `blank_n` high, `color_idx` holds its value.
- R10: `color_idx` is a registered output. It reflects, at the edge where the inputs are sampled, the state produced by those inputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| dot_en | input | 1 | Dot-clock enable at the highest pixel rate |
| load_en | input | 1 | Load strobe for a new byte |
| load_byte | input | 8 | Video memory byte |
| mode_sel | input | 2 | Display mode select, sampled on load |
| blank_n | input | 1 | Active-low blanking |
| color_idx | output | 4 | Colour index, registered |

## Verification
The checker assumes that a load comes with the mode it is meant to display. It also assumes that `blank_n` is high during reset, so that the hold property has a defined history. The stimulus meets both conditions. It loads a fresh byte every eight dot-enables and puts random idle cycles without `dot_en` between the shifts. It drops `blank_n` only for single random cycles, and it changes `mode_sel` between loads to show that the change is ignored.

// File: rtl/pxs_pkg.sv
package pxs_pkg;
  typedef enum logic [1:0] {
    MODE_C16  = 2'b00,
    MODE_C4   = 2'b01,
    MODE_C2   = 2'b10,
    MODE_C2_ALT = 2'b11
  } mode_e;

  localparam int DIV_W = 2;

  // dot-enables per pixel minus one
  function automatic logic [DIV_W-1:0] rate_limit(mode_e m);
    case (m)
      MODE_C16: rate_limit = 2'd3;
      MODE_C4:  rate_limit = 2'd1;
      default:  rate_limit = 2'd0;
    endcase
  endfunction

  function automatic logic [3:0] depth_mask(mode_e m);
    case (m)
      MODE_C16: depth_mask = 4'b1111;
      MODE_C4:  depth_mask = 4'b0011;
      default:  depth_mask = 4'b0001;
    endcase
  endfunction
endpackage

// File: rtl/pxs_rate_div.sv
module pxs_rate_div
  import pxs_pkg::*;
(
  input  logic  clk,
  input  logic  rst,
  input  logic  dot_en,
  input  logic  load_en,
  input  mode_e cur_mode,
  output logic  shift_pulse
);
  logic [DIV_W-1:0] cnt_q;

  assign shift_pulse = dot_en && !load_en && (cnt_q == rate_limit(cur_mode));

  always_ff @(posedge clk) begin
    if (rst || load_en) begin
      cnt_q <= '0;
    end else if (dot_en) begin
      cnt_q <= shift_pulse ? '0 : cnt_q + 1'b1;
    end
  end
endmodule

// File: rtl/pxs_shift_reg.sv
module pxs_shift_reg
  import pxs_pkg::*;
#(
  parameter int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load_en,
  input  logic [BYTE_W-1:0] load_byte,
  input  logic [1:0]        mode_sel,
  input  logic              shift_pulse,
  output logic [BYTE_W-1:0] sreg_nxt,
  output mode_e             mode_q,
  output mode_e             mode_nxt
);
  logic [BYTE_W-1:0] sreg_q;

  always_comb begin
    sreg_nxt = sreg_q;
    mode_nxt = mode_q;
    if (load_en) begin
      sreg_nxt = load_byte;
      mode_nxt = mode_e'(mode_sel);
    end else if (shift_pulse) begin
      sreg_nxt = {sreg_q[BYTE_W-2:0], 1'b0};
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      sreg_q <= '0;
      mode_q <= MODE_C2;
    end else begin
      sreg_q <= sreg_nxt;
      mode_q <= mode_nxt;
    end
  end
endmodule

// File: rtl/pxs_tap_sel.sv
module pxs_tap_sel
  import pxs_pkg::*;
#(
  parameter int BYTE_W = 8
) (
  input  logic [BYTE_W-1:0] sreg,
  input  mode_e             mode,
  output logic [3:0]        idx
);
  localparam int TAP0 = BYTE_W - 1;
  localparam int TAP1 = BYTE_W / 2 - 1;
  localparam int TAP2 = BYTE_W - 3;
  localparam int TAP3 = BYTE_W / 2 - 3;

  logic [3:0] raw;
  assign raw = {sreg[TAP3], sreg[TAP2], sreg[TAP1], sreg[TAP0]};
  assign idx = raw & depth_mask(mode);
endmodule

// File: rtl/pixel_serializer.sv
module pixel_serializer
  import pxs_pkg::*;
#(
  parameter int BYTE_W = 8,
  parameter int IDX_W  = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              dot_en,
  input  logic              load_en,
  input  logic [BYTE_W-1:0] load_byte,
  input  logic [1:0]        mode_sel,
  input  logic              blank_n,
  output logic [IDX_W-1:0]  color_idx
);
  logic              shift_pulse;
  logic [BYTE_W-1:0] sreg_nxt;
  mode_e             mode_q;
  mode_e             mode_nxt;
  logic [3:0]        idx_nxt;

  pxs_rate_div u_div (
    .clk        (clk),
    .rst        (rst),
    .dot_en     (dot_en),
    .load_en    (load_en),
    .cur_mode   (mode_q),
    .shift_pulse(shift_pulse)
  );

  pxs_shift_reg #(.BYTE_W(BYTE_W)) u_sreg (
    .clk        (clk),
    .rst        (rst),
    .load_en    (load_en),
    .load_byte  (load_byte),
    .mode_sel   (mode_sel),
    .shift_pulse(shift_pulse),
    .sreg_nxt   (sreg_nxt),
    .mode_q     (mode_q),
    .mode_nxt   (mode_nxt)
  );

  pxs_tap_sel #(.BYTE_W(BYTE_W)) u_tap (
    .sreg(sreg_nxt),
    .mode(mode_nxt),
    .idx (idx_nxt)
  );

  always_ff @(posedge clk) begin
    if (rst || !blank_n) begin
      color_idx <= '0;
    end else begin
      color_idx <= IDX_W'(idx_nxt);
    end
  end
endmodule

// File: rtl/pixel_serializer_checker.sv
module pixel_serializer_checker (
  input logic       clk,
  input logic       rst,
  input logic       dot_en,
  input logic       load_en,
  input logic [7:0] load_byte,
  input logic [1:0] mode_sel,
  input logic       blank_n,
  input logic [3:0] color_idx
);
  assert_reset_zero_R1: assert property (@(posedge clk)
    rst |=> color_idx == 4'd0);

  assert_c2_depth_R2: assert property (@(posedge clk) disable iff (rst)
    (load_en && mode_sel[1]) |=> color_idx[3:1] == 3'd0);

  assert_c4_first_pixel_R3: assert property (@(posedge clk) disable iff (rst)
    (load_en && mode_sel == 2'b01 && blank_n) |=>
      color_idx == {2'b00, $past(load_byte[3]), $past(load_byte[7])});

  assert_c16_first_pixel_R4: assert property (@(posedge clk) disable iff (rst)
    (load_en && mode_sel == 2'b00 && blank_n) |=>
      color_idx == {$past(load_byte[1]), $past(load_byte[5]),
                    $past(load_byte[3]), $past(load_byte[7])});

  assert_blank_zero_R8: assert property (@(posedge clk) disable iff (rst)
    !blank_n |=> color_idx == 4'd0);

  assert_idle_hold_R9: assert property (@(posedge clk) disable iff (rst)
    (!load_en && !dot_en && blank_n && $past(blank_n)) |=> $stable(color_idx));
endmodule

bind pixel_serializer pixel_serializer_checker u_chk (
  .clk      (clk),
  .rst      (rst),
  .dot_en   (dot_en),
  .load_en  (load_en),
  .load_byte(load_byte),
  .mode_sel (mode_sel),
  .blank_n  (blank_n),
  .color_idx(color_idx)
);

// File: tb/pixel_serializer_test.sv
`timescale 1ns/1ps
module pixel_serializer_test;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       dot_en = 1'b0;
  logic       load_en = 1'b0;
  logic [7:0] load_byte = 8'h00;
  logic [1:0] mode_sel = 2'b10;
  logic       blank_n = 1'b1;
  logic [3:0] color_idx;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  bit done = 0;

  always #4 clk = ~clk;

  pixel_serializer uut (
    .clk(clk), .rst(rst), .dot_en(dot_en), .load_en(load_en),
    .load_byte(load_byte), .mode_sel(mode_sel), .blank_n(blank_n),
    .color_idx(color_idx)
  );

  function automatic logic [3:0] expect_idx(logic [7:0] b, logic [1:0] m, int dots);
    int p;
    case (m)
      2'b00: begin p = dots / 4; expect_idx = {b[1-p], b[5-p], b[3-p], b[7-p]}; end
      2'b01: begin p = dots / 2; expect_idx = {2'b00, b[3-p], b[7-p]}; end
      default: begin p = dots; expect_idx = {3'b000, b[7-p]}; end
    endcase
  endfunction

  task automatic check(string req, logic [3:0] exp);
    checks++;
    if (color_idx !== exp) begin
      errors++;
      $display("FAIL %s: color_idx=%h expected=%h at cycle %0d", req, color_idx, exp, cycles);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  // One byte: load, then 7 further dot-enables with random idle gaps.
  task automatic run_byte(logic [7:0] b, logic [1:0] m, bit rnd, string req);
    int dots = 0;
    load_byte = b; mode_sel = m; load_en = 1'b1; dot_en = rnd ? 1'($urandom_range(0, 1)) : 1'b1;
    blank_n = 1'b1;
    step();
    load_en = 1'b0;
    check(req, expect_idx(b, m, 0));
    while (dots < 7) begin
      bit d = rnd ? ($urandom_range(0, 3) != 0) : 1'b1;
      bit bl = rnd ? ($urandom_range(0, 7) == 0) : 1'b0;
      if (rnd && $urandom_range(0, 3) == 0) mode_sel = 2'($urandom_range(0, 3)); // R7
      dot_en = d;
      blank_n = !bl;
      step();
      if (d) dots++;
      if (bl) check("R8", 4'd0);
      else check(d ? req : "R9", expect_idx(b, m, dots));
    end
    dot_en = 1'b0; blank_n = 1'b1;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000 && !done) begin
      done = 1;
      errors++; checks++;
      $display("FAIL watchdog: expired actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd2024));
    step(); step();
    check("R1", 4'd0);
    rst = 1'b0;
    step();
    check("R1", 4'd0);

    run_byte(8'hA5, 2'b10, 0, "R2");
    run_byte(8'h5A, 2'b11, 0, "R5");
    run_byte(8'h9C, 2'b01, 0, "R3");
    run_byte(8'h2B, 2'b00, 0, "R4");
    run_byte(8'hD4, 2'b00, 0, "R4");

    // R6: load in mid-pixel with dot_en low restarts the pixel sequence
    load_byte = 8'hF0; mode_sel = 2'b01; load_en = 1'b1; dot_en = 1'b1; step();
    load_en = 1'b0; step();
    load_byte = 8'h11; mode_sel = 2'b00; load_en = 1'b1; dot_en = 1'b0; step();
    load_en = 1'b0;
    check("R6", expect_idx(8'h11, 2'b00, 0));
    dot_en = 1'b1;
    for (int k = 1; k <= 4; k++) begin
      step();
      check("R6", expect_idx(8'h11, 2'b00, k));
    end
    dot_en = 1'b0;

    // R7: mode change without load keeps 16-colour grouping
    run_byte(8'hC3, 2'b00, 0, "R4");
    load_byte = 8'hB6; mode_sel = 2'b00; load_en = 1'b1; dot_en = 1'b1; step();
    load_en = 1'b0; mode_sel = 2'b10;
    for (int k = 1; k <= 3; k++) begin
      step();
      check("R7", expect_idx(8'hB6, 2'b00, k));
    end

    // R10: reset mid-stream clears output at the sampled edge
    rst = 1'b1; step();
    check("R1", 4'd0);
    rst = 1'b0; dot_en = 1'b0;

    for (int i = 0; i < 60; i++) begin
      logic [1:0] m = 2'($urandom_range(0, 3));
      run_byte(8'($urandom_range(0, 255)), m,
               1, m == 2'b00 ? "R4" : (m == 2'b01 ? "R3" : "R2"));
    end

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule